// File: doc/BRIEF.md
# Return-Address-Stack Hint Decoder

This block looks at one fetched instruction word and its program counter. The word is either a 32-bit instruction or a 16-bit compressed instruction held in the low half. The block tells a front-end predictor four things:
- whether the instruction is an unconditional jump;
- whether the jump goes through a register;
- what the return-address stack should do (push, pop, or both at once);
- which return address to push.

It also produces the jump target. For direct jumps the target is the PC plus the encoded offset. For register jumps it is the supplied rs1 value plus the immediate.

The push/pop choice does not follow from the opcode alone. Only x1 and x5 count as link registers. The decision looks at whether the destination and source are link registers and whether they are the same register. A jump that returns through one link register and links through the other asks for a pop and a push in the same cycle, which gives an atomic coroutine swap. The link address is always the next sequential PC, never the target.

A parameter selects one of two output modes: registered, with one cycle of latency and a reset, or purely combinational. The stack storage and the rest of instruction decode live elsewhere.

Top module: `ras_hint_decoder`

## Requirements
- R1: A 32-bit JAL (opcode bits [6:0] = 1101111) gives isJump=1, isIndirect=0 and pop=0. It gives push=1 exactly when rd (bits [11:7]) is 1 or 5.
- R2: A 32-bit JALR (opcode 1100111, funct3 bits [14:12] = 000) gives pop=1 and push=0 when rs1 (bits [19:15]) is 1 or 5 and rd is neither.
- R3: A JALR gives push=1 and pop=0 in two cases: rd is a link register and rs1 is not, or rd and rs1 are the same link register. A JALR that touches no link register gives neither push nor pop.
- R4: A JALR whose rd and rs1 are both link registers with different indices gives push=1 and pop=1 in the same cycle.
- R5: The JAL target is pc plus the sign-extended 21-bit J-immediate. The JALR target is rs1Val plus the sign-extended 12-bit immediate (bits [31:20]), with bit 0 cleared. JALR and the compressed register jumps give isIndirect=1.
- R6: linkAddr equals pc+4 when isCompressed=0 and pc+2 when isCompressed=1, wrapping modulo 2^XLEN, whatever the target is.
- R7: A compressed register jump (bits [1:0]=10, [15:13]=100, bit 12 clear, bits [6:2]=0, rs1 in bits [11:7] nonzero) is an indirect jump to rs1Val with bit 0 cleared. It never pushes, and it pops exactly when rs1 is 1 or 5.
- R8: The compressed linking register jump (same fields, but bit 12 set) always pushes. It also pops exactly when rs1 is 5. Its target is rs1Val with bit 0 cleared.
- R9: A compressed direct jump (bits [1:0]=01, [15:13]=101) is a jump to pc plus its sign-extended 12-bit offset. It gives neither push nor pop and isIndirect=0.
- R10: All of the following give isJump, push, pop and isIndirect low and target 0: compressed register forms with rs1=0 or bits [6:2] nonzero, JALR with funct3 not 000, any other opcode, and a word whose bits [1:0] disagree with isCompressed (11 with the flag set, anything else with it clear).
- R11: With REG_OUT=1, outputs reflect the inputs present at the previous rising clock edge. While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| instr | input | 32 | Fetched instruction; a compressed one occupies bits [15:0] |
| isCompressed | input | 1 | Set when instr holds a 16-bit instruction |
| pc | input | XLEN | Address of the instruction |
| rs1Val | input | XLEN | Value of the source register for register jumps |
| isJump | output | 1 | Instruction is an unconditional jump |
| push | output | 1 | Return-address stack should push linkAddr |
| pop | output | 1 | Return-address stack should pop |
| linkAddr | output | XLEN | Next sequential PC, the address to push |
| target | output | XLEN | Jump target, 0 for non-jumps |
| isIndirect | output | 1 | Target comes from a register |

## Verification
Pop and push can be requested in the same cycle. This happens when the swap rule of R4 applies, and when the compressed linking jump uses x5 (R8). The bench provokes both cases by sweeping rd and rs1 over {0, 1, 5, 7} for every JALR immediate it applies, and rs1 over the same set for both compressed register forms. Each vector's expected push and pop come from the link-register equalities alone. Every output is compared one clock after it is applied, so a swap that reports only one of the two strobes is caught.

// File: rtl/rhd_pkg.sv
package rhd_pkg;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0,
    IMM_I    = 2'd1,
    IMM_J    = 2'd2,
    IMM_CJ   = 2'd3
  } immSel_e;

  typedef struct packed {
    logic    isJump;
    logic    push;
    logic    pop;
    logic    isIndirect;
    immSel_e immSel;
  } hintStrobes_t;

  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;

  function automatic logic isLinkReg(input logic [4:0] idx);
    return (idx == 5'd1) || (idx == 5'd5);
  endfunction

endpackage

// File: rtl/rhd_ctrl.sv
module rhd_ctrl
  import rhd_pkg::*;
(
  input  logic [31:0]  instr,
  input  logic         isCompressed,
  output hintStrobes_t strobes
);

  logic [4:0] rdIdx;
  logic [4:0] rs1Idx;
  logic       rdLink;
  logic       rs1Link;
  logic [4:0] cRs1;
  logic [4:0] cRs2;
  logic       cRegJumpForm;
  logic       cDirectForm;

  assign rdIdx   = instr[11:7];
  assign rs1Idx  = instr[19:15];
  assign rdLink  = isLinkReg(rdIdx);
  assign rs1Link = isLinkReg(rs1Idx);

  assign cRs1 = instr[11:7];
  assign cRs2 = instr[6:2];
  assign cRegJumpForm = (instr[1:0] == 2'b10) && (instr[15:13] == 3'b100)
                        && (cRs2 == 5'd0) && (cRs1 != 5'd0);
  assign cDirectForm  = (instr[1:0] == 2'b01) && (instr[15:13] == 3'b101);

  always_comb begin
    strobes = '{isJump: 1'b0, push: 1'b0, pop: 1'b0,
                isIndirect: 1'b0, immSel: IMM_NONE};
    if (isCompressed) begin
      if (cRegJumpForm) begin
        strobes.isJump     = 1'b1;
        strobes.isIndirect = 1'b1;
        strobes.immSel     = IMM_NONE;
        if (instr[12]) begin
          // linking form writes x1 implicitly
          strobes.push = 1'b1;
          strobes.pop  = (cRs1 == 5'd5);
        end else begin
          strobes.pop = isLinkReg(cRs1);
        end
      end else if (cDirectForm) begin
        strobes.isJump = 1'b1;
        strobes.immSel = IMM_CJ;
      end
    end else if (instr[1:0] == 2'b11) begin
      if (instr[6:0] == OPC_JAL) begin
        strobes.isJump = 1'b1;
        strobes.push   = rdLink;
        strobes.immSel = IMM_J;
      end else if ((instr[6:0] == OPC_JALR) && (instr[14:12] == 3'b000)) begin
        strobes.isJump     = 1'b1;
        strobes.isIndirect = 1'b1;
        strobes.immSel     = IMM_I;
        strobes.push       = rdLink;
        strobes.pop        = rs1Link && (!rdLink || (rdIdx != rs1Idx));
      end
    end
  end

endmodule

// File: rtl/rhd_datapath.sv
module rhd_datapath
  import rhd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic            isCompressed,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1Val,
  input  hintStrobes_t    strobes,
  output logic [XLEN-1:0] linkAddr,
  output logic [XLEN-1:0] target
);

  localparam int IEXT  = XLEN - 12;
  localparam int JEXT  = XLEN - 21;
  localparam logic [XLEN-1:0] STEP_C = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(4);

  logic [XLEN-1:0] immI;
  logic [XLEN-1:0] immJ;
  logic [XLEN-1:0] immCj;
  logic [XLEN-1:0] immSel;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  assign immI  = {{IEXT{instr[31]}}, instr[31:20]};
  assign immJ  = {{JEXT{instr[31]}}, instr[31], instr[19:12], instr[20],
                  instr[30:21], 1'b0};
  assign immCj = {{IEXT{instr[12]}}, instr[12], instr[8], instr[10:9], instr[6],
                  instr[7], instr[2], instr[11], instr[5:3], 1'b0};

  always_comb begin
    unique case (strobes.immSel)
      IMM_I:   immSel = immI;
      IMM_J:   immSel = immJ;
      IMM_CJ:  immSel = immCj;
      default: immSel = '0;
    endcase
  end

  assign base = strobes.isIndirect ? rs1Val : pc;
  assign sum  = base + immSel;

  always_comb begin
    if (!strobes.isJump)         target = '0;
    else if (strobes.isIndirect) target = {sum[XLEN-1:1], 1'b0};
    else                         target = sum;
  end

  assign linkAddr = pc + (isCompressed ? STEP_C : STEP_W);

endmodule

// File: rtl/ras_hint_decoder.sv
module ras_hint_decoder
  import rhd_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     instr,
  input  logic            isCompressed,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs1Val,
  output logic            isJump,
  output logic            push,
  output logic            pop,
  output logic [XLEN-1:0] linkAddr,
  output logic [XLEN-1:0] target,
  output logic            isIndirect
);

  hintStrobes_t    strobes;
  logic [XLEN-1:0] linkComb;
  logic [XLEN-1:0] targetComb;

  rhd_ctrl u_ctrl (
    .instr        (instr),
    .isCompressed (isCompressed),
    .strobes      (strobes)
  );

  rhd_datapath #(.XLEN(XLEN)) u_dp (
    .instr        (instr),
    .isCompressed (isCompressed),
    .pc           (pc),
    .rs1Val       (rs1Val),
    .strobes      (strobes),
    .linkAddr     (linkComb),
    .target       (targetComb)
  );

  generate
    if (REG_OUT) begin : gRegOut
      logic primed;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          isJump     <= 1'b0;
          push       <= 1'b0;
          pop        <= 1'b0;
          isIndirect <= 1'b0;
          linkAddr   <= '0;
          target     <= '0;
          primed     <= 1'b0;
        end else begin
          isJump     <= strobes.isJump;
          push       <= strobes.push;
          pop        <= strobes.pop;
          isIndirect <= strobes.isIndirect;
          linkAddr   <= linkComb;
          target     <= targetComb;
          primed     <= 1'b1;
        end
      end

      assert_push_is_jump_R10: assert property (@(posedge clk) disable iff (!rstN)
        push |-> isJump);

      assert_pop_is_jump_R10: assert property (@(posedge clk) disable iff (!rstN)
        pop |-> (isJump && isIndirect));

      assert_jal_push_R1: assert property (@(posedge clk) disable iff (!rstN)
        (primed && !$past(isCompressed) && ($past(instr[6:0]) == OPC_JAL))
        |-> (!pop && (push == (($past(instr[11:7]) == 5'd1) ||
                               ($past(instr[11:7]) == 5'd5)))));

      assert_swap_R4: assert property (@(posedge clk) disable iff (!rstN)
        (primed && !$past(isCompressed) && ($past(instr[6:0]) == OPC_JALR)
         && ($past(instr[14:12]) == 3'b000)
         && (($past(instr[11:7]) == 5'd1 && $past(instr[19:15]) == 5'd5) ||
             ($past(instr[11:7]) == 5'd5 && $past(instr[19:15]) == 5'd1)))
        |-> (push && pop));

      assert_link_step_R6: assert property (@(posedge clk) disable iff (!rstN)
        primed |-> (linkAddr == ($past(pc) + ($past(isCompressed) ? XLEN'(2) : XLEN'(4)))));

      assert_creg_no_push_R7: assert property (@(posedge clk) disable iff (!rstN)
        (primed && $past(isCompressed) && ($past(instr[15:12]) == 4'b1000)
         && ($past(instr[1:0]) == 2'b10)) |-> !push);
    end else begin : gComb
      assign isJump     = strobes.isJump;
      assign push       = strobes.push;
      assign pop        = strobes.pop;
      assign isIndirect = strobes.isIndirect;
      assign linkAddr   = linkComb;
      assign target     = targetComb;
    end
  endgenerate

endmodule

// File: tb/ras_hint_decoder_bench.sv
module ras_hint_decoder_bench;

  localparam int XLEN = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  logic        isCompressed = 1'b0;
  logic [31:0] pc = '0;
  logic [31:0] rs1Val = '0;
  logic        isJump, push, pop, isIndirect;
  logic [31:0] linkAddr, target;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ras_hint_decoder #(.XLEN(XLEN), .REG_OUT(1'b1)) u_ras_hint_decoder (
    .clk(clk), .rstN(rstN), .instr(instr), .isCompressed(isCompressed),
    .pc(pc), .rs1Val(rs1Val), .isJump(isJump), .push(push), .pop(pop),
    .linkAddr(linkAddr), .target(target), .isIndirect(isIndirect)
  );

  function automatic logic [31:0] encJal(input logic [4:0] rd, input logic [20:0] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] encJalr(input logic [4:0] rd, input logic [4:0] rs1,
                                          input logic [11:0] imm, input logic [2:0] f3);
    return {imm, rs1, f3, rd, 7'b1100111};
  endfunction

  function automatic logic [31:0] encCj(input logic [11:0] o);
    return {16'h0, 3'b101, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction

  function automatic logic [31:0] encCr(input logic f1, input logic [4:0] rs1,
                                        input logic [4:0] rs2);
    return {16'h0, 3'b100, f1, rs1, rs2, 2'b10};
  endfunction

  function automatic logic isLink(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  task automatic cmp1(string tag, string name, logic act, logic exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
    end
  endtask

  task automatic cmpW(string tag, string name, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, name, act, exp);
    end
  endtask

  task automatic runVec(string tag, logic [31:0] ins, logic comp, logic [31:0] pcv,
                        logic [31:0] r1, logic eJ, logic ePush, logic ePop,
                        logic eInd, logic [31:0] eTgt);
    logic [31:0] eLink;
    eLink = pcv + (comp ? 32'd2 : 32'd4);
    @(negedge clk);
    instr = ins; isCompressed = comp; pc = pcv; rs1Val = r1;
    @(negedge clk);
    vectors++;
    cmp1(tag, "isJump", isJump, eJ);
    cmp1(tag, "push", push, ePush);
    cmp1(tag, "pop", pop, ePop);
    cmp1(tag, "isIndirect", isIndirect, eInd);
    cmpW(tag, "target", target, eTgt);
    cmpW(tag, "linkAddr(R6)", linkAddr, eLink);
  endtask

  initial begin : watchdog
    #1_500_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0]  regSet [4];
    logic [20:0] jImm [4];
    logic [11:0] iImm [3];
    logic [11:0] cOff [4];
    regSet = '{5'd0, 5'd1, 5'd5, 5'd7};
    jImm   = '{21'h000010, 21'h1FFFFC, 21'h0FFFFE, 21'h100000};
    iImm   = '{12'h000, 12'h7FF, 12'h800};
    cOff   = '{12'h002, 12'hFFE, 12'h7FE, 12'h800};

    // R11: reset holds outputs at zero even with a pushing JAL applied
    instr = encJal(5'd1, 21'h40); pc = 32'h1000;
    repeat (3) @(negedge clk);
    vectors++;
    cmp1("R11", "isJump", isJump, 1'b0);
    cmp1("R11", "push", push, 1'b0);
    cmpW("R11", "linkAddr", linkAddr, 32'h0);
    cmpW("R11", "target", target, 32'h0);
    rstN = 1'b1;

    // R1/R5: JAL over rd set and offsets, including pc wrap
    foreach (regSet[i]) begin
      foreach (jImm[k]) begin
        logic [31:0] pcv;
        logic [31:0] off;
        pcv = (k == 1) ? 32'h0000_0002 : 32'h8000_0100 + 32'(i * 64);
        off = {{11{jImm[k][20]}}, jImm[k]};
        runVec("R1", encJal(regSet[i], jImm[k]), 1'b0, pcv, 32'h0,
               1'b1, isLink(regSet[i]), 1'b0, 1'b0, pcv + off);
      end
    end

    // R2/R3/R4/R5: JALR over every rd x rs1 pair
    foreach (regSet[i]) begin
      foreach (regSet[j]) begin
        foreach (iImm[k]) begin
          logic [4:0]  rd, rs;
          logic        ePush, ePop;
          logic [31:0] r1, sum;
          string       tag;
          rd = regSet[i]; rs = regSet[j];
          r1 = 32'h1234_5671 + 32'(k * 32'h0100_0003);
          sum = r1 + {{20{iImm[k][11]}}, iImm[k]};
          ePush = isLink(rd);
          ePop  = isLink(rs) && (!isLink(rd) || rd != rs);
          if (ePush && ePop) tag = "R4";
          else if (ePop)     tag = "R2";
          else               tag = "R3";
          runVec(tag, encJalr(rd, rs, iImm[k], 3'b000), 1'b0, 32'h0000_4000,
                 r1, 1'b1, ePush, ePop, 1'b1, {sum[31:1], 1'b0});
        end
      end
    end

    // R7 and R8: compressed register jumps, rs1 over the set (rs1=0 is R10)
    foreach (regSet[j]) begin
      logic [4:0] rs;
      rs = regSet[j];
      if (rs == 5'd0) begin
        runVec("R10", encCr(1'b0, rs, 5'd0), 1'b1, 32'h200, 32'h55, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        runVec("R10", encCr(1'b1, rs, 5'd0), 1'b1, 32'h200, 32'h55, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
      end else begin
        runVec("R7", encCr(1'b0, rs, 5'd0), 1'b1, 32'hFFFF_FFFE, 32'h0000_3003,
               1'b1, 1'b0, isLink(rs), 1'b1, 32'h0000_3002);
        runVec("R8", encCr(1'b1, rs, 5'd0), 1'b1, 32'h0000_0700, 32'h0000_8889,
               1'b1, 1'b1, (rs == 5'd5), 1'b1, 32'h0000_8888);
      end
    end

    // R9: compressed direct jump offsets
    foreach (cOff[k]) begin
      logic [31:0] pcv;
      pcv = 32'h0001_0000;
      runVec("R9", encCj(cOff[k]), 1'b1, pcv, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0,
             pcv + {{20{cOff[k][11]}}, cOff[k]});
    end

    // R10: non-jump and mismatched encodings
    runVec("R10", encJalr(5'd1, 5'd5, 12'h4, 3'b001), 1'b0, 32'h100, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    runVec("R10", 32'h0000_0013, 1'b0, 32'h100, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    runVec("R10", encCr(1'b0, 5'd1, 5'd3), 1'b1, 32'h100, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    runVec("R10", encJal(5'd1, 21'h40), 1'b1, 32'h100, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    runVec("R10", encCj(12'h010), 1'b0, 32'h100, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    runVec("R10", encCr(1'b1, 5'd1, 5'd0), 1'b0, 32'h100, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);

    // R6: link wrap for 32-bit at top of address space
    runVec("R6", encJal(5'd5, 21'h8), 1'b0, 32'hFFFF_FFFC, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0004);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule